// File: doc/BRIEF.md
# Byte-Vector Horizontal Reducer

This block folds neighbouring bytes of one 128-bit vector into wider results. A mode select picks how many neighbours are combined: pairs, groups of four or groups of eight. Each result lane is wide enough for its group: 16 bits for a pair, 32 bits for a group of four and 64 bits for a group of eight. A separate control replaces the pair sum with the difference of the two bytes in each pair. A third control chooses whether bytes are read as signed or unsigned values.

The result is registered. A request presented with `in_valid` high produces its result one clock later, with `out_valid` raised in that cycle. When `in_valid` is low the output register keeps its last value. The byte at bit position 8*i of `in_vec` is element i. Result lane k sits at the low end of the output, at bit offset k times the lane width.

Top module: `hsum_reducer`

## Requirements
- R1: With `group_sel`=0 and `sub_en`=0, output lane k (16 bits, bits 16k+15:16k) equals element 2k plus element 2k+1, for k = 0 to 7.
- R2: With `group_sel`=1 and `sub_en`=0, output lane k (32 bits, bits 32k+31:32k) equals the sum of elements 4k to 4k+3, for k = 0 to 3.
- R3: With `group_sel`=2 and `sub_en`=0, output lane k (64 bits, bits 64k+63:64k) equals the sum of elements 8k to 8k+7, for k = 0 and 1. In unsigned mode no result bit at or above bit 11 of a lane is ever set.
- R4: With `signed_en`=1 each byte is treated as two's complement and sign-extended to the lane width before summing. With `signed_en`=0 each byte is zero-extended.
- R5: With `sub_en`=1, output lane k (16 bits) equals the signed byte 2k minus the signed byte 2k+1. This holds whatever the value of `signed_en`, so every result lies in the range -255 to 255.
- R6: With `sub_en`=1, any value of `group_sel` gives the pair difference of R5.
- R7: With `group_sel`=3 and `sub_en`=0, the result is the pair sum of R1.
- R8: `out_valid` equals the value `in_valid` had one clock earlier.
- R9: While `in_valid` is low, `out_vec` does not change.
- R10: While `rst_n` is low, `out_valid` and `out_vec` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; the result register loads when high |
| in_vec | input | 128 | Sixteen source bytes, element i at bits 8i+7:8i |
| group_sel | input | 2 | 0 = pairs, 1 = groups of four, 2 = groups of eight, 3 = pairs |
| sub_en | input | 1 | Pair difference instead of sum |
| signed_en | input | 1 | 1 = signed bytes, 0 = unsigned bytes |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_vec | output | 128 | Widened result lanes |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle relation between `in_valid` and `out_valid`;
- that the output holds while no request is presented;
- that each difference lane stays a sign-extended 9-bit value;
- that unsigned groups of eight never set a lane bit at or above bit 11.

The exact arithmetic is shown only by the bench, which compares each result against its own model. This covers each group size and both extension rules. It also covers the rule that a difference ignores `group_sel` and `signed_en`. Directed extremes such as all 0xFF, and 0x80 against 0x7F, exercise the carry and sign boundaries.

// File: rtl/hsum_reducer.sv
module hsum_reducer #(
  parameter int ELEMS = 16,
  parameter int EW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [ELEMS*EW-1:0] in_vec,
  input  logic [1:0]          group_sel,
  input  logic                sub_en,
  input  logic                signed_en,
  output logic                out_valid,
  output logic [ELEMS*EW-1:0] out_vec
);
  localparam int VW = ELEMS * EW;
  localparam int PW = 2 * EW;
  localparam int QW = 4 * EW;
  localparam int OW = 8 * EW;
  localparam int NP = ELEMS / 2;
  localparam int NQ = ELEMS / 4;
  localparam int NO = ELEMS / 8;

  logic [NP-1:0][PW-1:0] pair_sum, pair_dif;
  logic [NQ-1:0][QW-1:0] quad_sum;
  logic [NO-1:0][OW-1:0] oct_sum;
  logic [VW-1:0]         next_vec;

  for (genvar k = 0; k < NP; k++) begin : g_pair
    logic [EW-1:0] a, b;
    assign a = in_vec[(2*k)*EW +: EW];
    assign b = in_vec[(2*k+1)*EW +: EW];
    assign pair_sum[k] = {{EW{signed_en & a[EW-1]}}, a} + {{EW{signed_en & b[EW-1]}}, b};
    assign pair_dif[k] = {{EW{a[EW-1]}}, a} - {{EW{b[EW-1]}}, b};
  end

  for (genvar k = 0; k < NQ; k++) begin : g_quad
    logic [PW-1:0] p0, p1;
    assign p0 = pair_sum[2*k];
    assign p1 = pair_sum[2*k+1];
    assign quad_sum[k] = {{(QW-PW){signed_en & p0[PW-1]}}, p0} + {{(QW-PW){signed_en & p1[PW-1]}}, p1};
  end

  for (genvar k = 0; k < NO; k++) begin : g_oct
    logic [QW-1:0] q0, q1;
    assign q0 = quad_sum[2*k];
    assign q1 = quad_sum[2*k+1];
    assign oct_sum[k] = {{(OW-QW){signed_en & q0[QW-1]}}, q0} + {{(OW-QW){signed_en & q1[QW-1]}}, q1};
  end

  assign next_vec = sub_en             ? pair_dif :
                    (group_sel == 2'd1) ? quad_sum :
                    (group_sel == 2'd2) ? oct_sum  : pair_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= next_vec;
    end
  end

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec));

  for (genvar k = 0; k < NP; k++) begin : g_chk_dif
    assert_dif_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sub_en) |=>
        out_vec[k*PW+EW+1 +: PW-EW-1] == {(PW-EW-1){out_vec[k*PW+EW]}});
  end

  for (genvar k = 0; k < NO; k++) begin : g_chk_oct
    assert_oct_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sub_en && group_sel == 2'd2 && !signed_en) |=>
        out_vec[k*OW+EW+3 +: OW-EW-3] == '0);
  end
endmodule

// File: tb/hsum_reducer_bench.sv
`timescale 1ns/1ps
module hsum_reducer_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic [127:0] in_vec = '0;
  logic [1:0]   group_sel = '0;
  logic         sub_en = 0;
  logic         signed_en = 0;
  logic         out_valid;
  logic [127:0] out_vec;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hsum_reducer u_hsum_reducer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .group_sel(group_sel), .sub_en(sub_en), .signed_en(signed_en),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic longint elem(logic [127:0] v, int i, bit sgn);
    logic [7:0] b;
    b = v[8*i +: 8];
    if (sgn) return longint'($signed(b));
    return longint'(b);
  endfunction

  function automatic logic [127:0] model(logic [127:0] v, logic [1:0] g, bit sub, bit sgn);
    logic [127:0] r;
    logic [63:0]  s;
    int size;
    r = '0;
    if (sub) begin
      for (int k = 0; k < 8; k++) begin
        s = 64'(elem(v, 2*k, 1) - elem(v, 2*k+1, 1));
        r[16*k +: 16] = s[15:0];
      end
      return r;
    end
    size = (g == 2'd1) ? 4 : (g == 2'd2) ? 8 : 2;
    for (int k = 0; k < 16/size; k++) begin
      longint acc;
      acc = 0;
      for (int j = 0; j < size; j++) acc += elem(v, size*k+j, sgn);
      s = 64'(acc);
      for (int bt = 0; bt < 8*size; bt++) r[8*size*k + bt] = s[bt];
    end
    return r;
  endfunction

  function automatic string tag(logic [1:0] g, bit sub);
    if (sub) return (g == 2'd0) ? "R5" : "R6";
    case (g)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [127:0] v, logic [1:0] g, bit sub, bit sgn, string extra);
    logic [127:0] exp;
    exp = model(v, g, sub, sgn);
    @(negedge clk);
    in_vec = v; group_sel = g; sub_en = sub; signed_en = sgn; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({extra, tag(g, sub)}, out_vec, exp);
    check("R8", {127'd0, out_valid}, 128'd1);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10", out_vec, '0);
    check("R10", {127'd0, out_valid}, '0);
    rst_n = 1;

    run({16{8'hFF}}, 2'd2, 0, 0, "R4 ");
    run({16{8'hFF}}, 2'd2, 0, 1, "R4 ");
    run({16{8'h80}}, 2'd0, 0, 1, "R4 ");
    run({16{8'hFF}}, 2'd1, 0, 0, "R4 ");
    run({8{8'h80, 8'h7F}}, 2'd0, 1, 0, "");
    run({8{8'h7F, 8'h80}}, 2'd0, 1, 1, "");
    run({8{8'h7F, 8'h80}}, 2'd2, 1, 0, "");
    run({8{8'h12, 8'hF3}}, 2'd3, 0, 1, "");

    held = out_vec;
    @(negedge clk);
    in_vec = ~in_vec; group_sel = 2'd1;
    @(negedge clk);
    check("R9", out_vec, held);
    check("R8", {127'd0, out_valid}, '0);

    for (int i = 0; i < 300; i++) begin
      logic [127:0] v;
      v = {$urandom, $urandom, $urandom, $urandom};
      run(v, 2'($urandom), 1'($urandom), 1'($urandom), "");
    end

    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R10", out_vec, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule